// File: doc/BRIEF.md
# Instruction-Cycle Sequencer with Interrupt Entry

This block sequences a small accumulator-style machine through its instruction cycle. It holds a 4096-word by 16-bit store, the program counter, an address register, an instruction register, a temporary register used to save the return address, and three single-bit flags: interrupt enable, pending interrupt and the indirect bit of the current instruction. A four-bit step counter is decoded into sixteen one-hot timing strobes, and the opcode field of the instruction register is decoded into eight one-hot lines.

Each instruction boundary goes one of two ways, chosen by the pending-interrupt flag. With the flag clear, the controller fetches, decodes, optionally follows an indirect pointer and runs a minimal execute phase. Only the unconditional branch and the two interrupt-enable controls do anything. Every other opcode ends the instruction without effect. With the flag set, a three-step interrupt entry writes the current program counter into word 0, continues at word 1 and disables further interrupts. A service routine can then return with an indirect branch through word 0.

The store is loaded through a write port that is honoured only while reset is held. Arithmetic and device data transfer are not part of this block.

Top module: `instr_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, step counter, interrupt enable and pending flag all go to 0, and so do the address and instruction registers.
- R2: With no interrupt pending, the step counter advances by one per clock from 0. Step 0 copies PC into AR. Step 1 loads IR from the word at AR and increments PC. Step 2 loads AR from IR[11:0] and the indirect bit from IR[15].
- R3: Instruction word layout: bit 15 is the indirect flag, bits 14:12 the opcode, bits 11:0 the address. Opcode 111 with bit 15 clear is a register instruction that ends at step 3 with no effect, returning the step counter to 0.
- R4: Opcode 111 with bit 15 set is an I/O instruction ending at step 3. If IR bit 7 is set, interrupt enable becomes 1. If IR bit 6 is set, interrupt enable becomes 0.
- R5: A memory-reference instruction (opcode 000 to 110) with bit 15 set replaces AR with bits 11:0 of the word at AR during step 3. With bit 15 clear, step 3 changes nothing.
- R6: Opcode 100 (branch) loads PC from AR at step 4 and ends the instruction. Any other memory-reference opcode ends at step 4 with PC, AR and interrupt enable untouched.
- R7: The pending flag is set on any clock edge outside steps 0 to 2 where interrupt enable is 1 and either ready input is 1. It never changes during steps 0 and 1, and during step 2 it changes only in the interrupt entry.
- R8: With the pending flag set, step 0 clears AR and saves PC in TR. Step 1 writes TR into word 0 and clears PC. Step 2 sets PC to 1, clears interrupt enable and the pending flag, and returns the step counter to 0.
- R9: An indirect branch through word 0 after an interrupt entry resumes at the program counter value saved by that entry.
- R10: While interrupt enable is 0, the ready inputs never set the pending flag.
- R11: The preload port writes the store only while `rst` is high. A write request while running has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables preload |
| in_rdy | input | 1 | Input device ready flag |
| out_rdy | input | 1 | Output device ready flag |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word value |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| ir_o | output | 16 | Instruction register |
| ien_o | output | 1 | Interrupt enable flag |
| r_o | output | 1 | Pending interrupt flag |
| step_o | output | 4 | Current step counter value |

## Verification
The hardest situation to reach from the ports is an interrupt request that lands in the execute phase of a known instruction. It has to be taken at the next boundary and then unwound by a service routine, so that the value saved in word 0 can be seen again as the program counter. The stimulus runs a two-instruction spin loop. It waits for the second fetch boundary at the loop's branch before raising the input-ready flag, so the flag is first seen during that branch's step 3. The flag is dropped once the pending bit shows. The bench then follows each step of the entry cycle and the indirect return, and afterwards holds the output-ready flag and a running preload request to show that neither changes the loop.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int ISC_ADDR_W = 12;
  localparam int ISC_WORD_W = 16;
  localparam int ISC_STEP_W = 4;
  localparam int ISC_OPC_W  = 3;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_REG = 2'd1,
    CLS_IO  = 2'd2
  } isc_class_e;

endpackage

// File: rtl/isc_seq_counter.sv
module isc_seq_counter #(
  parameter int STEP_W = 4,
  localparam int NT = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              clr,
  output logic [STEP_W-1:0] sc,
  output logic [NT-1:0]     t
);

  logic [STEP_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) sc_q <= '0;
    else if (inc)   sc_q <= sc_q + 1'b1;
  end

  for (genvar k = 0; k < NT; k++) begin : g_tdec
    assign t[k] = (sc_q == STEP_W'(k));
  end

  assign sc = sc_q;

endmodule

// File: rtl/isc_op_decode.sv
module isc_op_decode #(
  parameter int OPC_W = 3,
  localparam int N_OPS = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc,
  output logic [N_OPS-1:0] d
);

  for (genvar k = 0; k < N_OPS; k++) begin : g_ddec
    assign d[k] = (opc == OPC_W'(k));
  end

endmodule

// File: rtl/isc_word_mem.sv
module isc_word_mem #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl
  import isc_pkg::*;
#(
  parameter int ADDR_W  = ISC_ADDR_W,
  parameter int WORD_W  = ISC_WORD_W,
  parameter int STEP_W  = ISC_STEP_W,
  parameter int ION_BIT = 7,
  parameter int IOF_BIT = 6,
  parameter int BUN_OPC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_rdy,
  input  logic              out_rdy,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [WORD_W-1:0] ir_o,
  output logic              ien_o,
  output logic              r_o,
  output logic [STEP_W-1:0] step_o
);

  localparam int OPC_W   = ISC_OPC_W;
  localparam int N_OPS   = 1 << OPC_W;
  localparam int NT      = 1 << STEP_W;
  localparam int IND_BIT = WORD_W - 1;
  localparam int OPC_LO  = WORD_W - 1 - OPC_W;
  localparam int PAD_W   = WORD_W - ADDR_W;

  // arithmetic and field extraction
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_field(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [OPC_W-1:0] opc_field(input logic [WORD_W-1:0] w);
    return w[OPC_LO +: OPC_W];
  endfunction

  function automatic isc_class_e class_of(input logic d_top, input logic ind);
    if (!d_top) return CLS_MEM;
    return ind ? CLS_IO : CLS_REG;
  endfunction

  // state
  logic [ADDR_W-1:0] pc_q, ar_q, tr_q;
  logic [WORD_W-1:0] ir_q;
  logic              ien_q, r_q, ind_q;

  logic [STEP_W-1:0] sc;
  logic [NT-1:0]     t;
  logic [N_OPS-1:0]  d;
  logic [WORD_W-1:0] mem_rd;
  isc_class_e        cls;

  // named internal events
  logic ev_fetch0, ev_fetch1, ev_fetch2;
  logic ev_int_t0, ev_int_save, ev_int_done;
  logic ev_indirect, ev_bun_take, ev_ion, ev_iof;
  logic ev_exec3_end, ev_mem_end, t_late;
  logic ev_set_r, sc_clr;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  isc_seq_counter #(.STEP_W(STEP_W)) u_seq (
    .clk (clk),
    .rst (rst),
    .inc (!sc_clr),
    .clr (sc_clr),
    .sc  (sc),
    .t   (t)
  );

  isc_op_decode #(.OPC_W(OPC_W)) u_opdec (
    .opc (opc_field(ir_q)),
    .d   (d)
  );

  isc_word_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ar_q),
    .rdata (mem_rd)
  );

  always_comb begin
    cls          = class_of(d[N_OPS-1], ind_q);
    ev_fetch0    = !r_q && t[0];
    ev_fetch1    = !r_q && t[1];
    ev_fetch2    = !r_q && t[2];
    ev_int_t0    = r_q && t[0];
    ev_int_save  = r_q && t[1];
    ev_int_done  = r_q && t[2];
    ev_indirect  = t[3] && (cls == CLS_MEM) && ind_q;
    ev_ion       = t[3] && (cls == CLS_IO) && ir_q[ION_BIT];
    ev_iof       = t[3] && (cls == CLS_IO) && ir_q[IOF_BIT];
    ev_exec3_end = t[3] && d[N_OPS-1];
    ev_mem_end   = t[4] && (|d[N_OPS-2:0]);
    ev_bun_take  = t[4] && d[BUN_OPC];
    t_late       = |t[NT-1:5];
    ev_set_r     = !(t[0] || t[1] || t[2]) && ien_q && (in_rdy || out_rdy);
    sc_clr       = ev_exec3_end || ev_mem_end || ev_int_done || t_late;
  end

  // store write port: preload during reset, return-address save otherwise
  always_comb begin
    if (rst) begin
      mem_we    = pre_we;
      mem_waddr = pre_addr;
      mem_wdata = pre_data;
    end else begin
      mem_we    = ev_int_save;
      mem_waddr = ar_q;
      mem_wdata = {{PAD_W{1'b0}}, tr_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ar_q  <= '0;
      tr_q  <= '0;
      ir_q  <= '0;
      ien_q <= 1'b0;
      r_q   <= 1'b0;
      ind_q <= 1'b0;
    end else begin
      if (ev_fetch0) ar_q <= pc_q;
      if (ev_fetch1) begin
        ir_q <= mem_rd;
        pc_q <= addr_next(pc_q);
      end
      if (ev_fetch2) begin
        ar_q  <= addr_field(ir_q);
        ind_q <= ir_q[IND_BIT];
      end
      if (ev_indirect) ar_q <= addr_field(mem_rd);
      if (ev_bun_take) pc_q <= ar_q;
      if (ev_int_t0) begin
        ar_q <= '0;
        tr_q <= pc_q;
      end
      if (ev_int_save) pc_q <= '0;
      if (ev_int_done) begin
        pc_q  <= addr_next(pc_q);
        ien_q <= 1'b0;
        r_q   <= 1'b0;
      end
      if (ev_ion) ien_q <= 1'b1;
      if (ev_iof) ien_q <= 1'b0;
      if (ev_set_r) r_q <= 1'b1;
    end
  end

  assign pc_o   = pc_q;
  assign ar_o   = ar_q;
  assign ir_o   = ir_q;
  assign ien_o  = ien_q;
  assign r_o    = r_q;
  assign step_o = sc;

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int ADDR_W = 12,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic              ien,
  input logic              r,
  input logic              ev_set_r,
  input logic              ev_bun_take
);

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && step == '0 && !ien && !r)); // R1

  AST_STEP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> (step == STEP_W'(1))); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |=> (step == '0 || step == STEP_W'($past(step) + 1'b1))); // R2

  AST_PC_FETCH_INC: assert property (@(posedge clk) disable iff (rst)
    (!r && step == STEP_W'(1)) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(4)); // R3

  AST_ION_AT_STEP3: assert property (@(posedge clk) disable iff (rst)
    $rose(ien) |-> ($past(step) == STEP_W'(3))); // R4

  AST_BUN_LOADS_PC: assert property (@(posedge clk) disable iff (rst)
    ev_bun_take |=> (pc == $past(ar))); // R6

  AST_SET_PENDING: assert property (@(posedge clk) disable iff (rst)
    ev_set_r |=> r); // R7

  AST_PENDING_STEADY_LOW: assert property (@(posedge clk) disable iff (rst)
    (!r && step <= STEP_W'(2)) |=> !r); // R7

  AST_PENDING_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (r && step <= STEP_W'(1)) |=> r); // R7

  AST_INT_AR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (r && step == '0) |=> (ar == '0)); // R8

  AST_INT_PC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (r && step == STEP_W'(1)) |=> (pc == '0)); // R8

  AST_INT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (r && step == STEP_W'(2)) |=> (pc == ADDR_W'(1) && !ien && !r && step == '0)); // R8

  AST_NO_PENDING_WITHOUT_IEN: assert property (@(posedge clk) disable iff (rst)
    $rose(r) |-> $past(ien)); // R10

endmodule

bind instr_seq_ctrl isc_checker #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_isc_chk (
  .clk         (clk),
  .rst         (rst),
  .step        (step_o),
  .pc          (pc_o),
  .ar          (ar_o),
  .ien         (ien_o),
  .r           (r_o),
  .ev_set_r    (ev_set_r),
  .ev_bun_take (ev_bun_take)
);

// File: tb/instr_seq_ctrl_tb_top.sv
module instr_seq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_rdy = 1'b0;
  logic          out_rdy = 1'b0;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [AW-1:0] pc_o, ar_o;
  logic [DW-1:0] ir_o;
  logic          ien_o, r_o;
  logic [SW-1:0] step_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] pc;
    logic          ien;
    logic          r;
    string         tag;
  } bnd_t;

  bnd_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_seq_ctrl dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_rdy   (in_rdy),
    .out_rdy  (out_rdy),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .pc_o     (pc_o),
    .ar_o     (ar_o),
    .ir_o     (ir_o),
    .ien_o    (ien_o),
    .r_o      (r_o),
    .step_o   (step_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver side of the scoreboard: expected instruction boundaries
  task automatic push_bnd(input logic [AW-1:0] pc, input logic ien,
                          input logic r, input string tag);
    bnd_t b;
    b.pc = pc; b.ien = ien; b.r = r; b.tag = tag;
    exp_q.push_back(b);
  endtask

  // monitor side: every step-0 sample is a boundary compared in order
  always @(negedge clk) begin
    bnd_t b;
    if (!rst && step_o == '0 && exp_q.size() > 0) begin
      b = exp_q.pop_front();
      check(pc_o == b.pc, b.tag, "boundary pc", int'(pc_o), int'(b.pc));
      check(ien_o == b.ien && r_o == b.r, b.tag, "boundary {ien,r}",
            int'({ien_o, r_o}), int'({b.ien, b.r}));
    end
  end

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = v;
  endtask

  task automatic wait_bnd(input logic [AW-1:0] pc);
    do @(negedge clk); while (!(step_o == '0 && pc_o == pc));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // expected boundaries after reset release (first one at pc 0 is skipped)
    push_bnd(12'h010, 1'b0, 1'b0, "R6");  // direct branch from 0
    push_bnd(12'h011, 1'b1, 1'b0, "R4");  // enable
    push_bnd(12'h012, 1'b0, 1'b0, "R4");  // disable
    push_bnd(12'h013, 1'b1, 1'b0, "R4");  // enable again
    push_bnd(12'h050, 1'b1, 1'b0, "R5");  // indirect branch via 0x030
    push_bnd(12'h051, 1'b1, 1'b0, "R3");  // register no-op
    push_bnd(12'h050, 1'b1, 1'b0, "R6");
    push_bnd(12'h051, 1'b1, 1'b0, "R3");
    push_bnd(12'h050, 1'b1, 1'b1, "R7");  // request taken during branch
    push_bnd(12'h001, 1'b0, 1'b0, "R8");  // after entry cycle
    push_bnd(12'h002, 1'b0, 1'b0, "R6");  // other memory opcode no effect
    push_bnd(12'h050, 1'b0, 1'b0, "R9");  // return through word 0
    push_bnd(12'h051, 1'b0, 1'b0, "R10");
    push_bnd(12'h050, 1'b0, 1'b0, "R11");
    push_bnd(12'h051, 1'b0, 1'b0, "R10");
    push_bnd(12'h050, 1'b0, 1'b0, "R11");

    // program: [15]=indirect, [14:12]=opcode, [11:0]=address
    preload(12'h000, 16'h4010);  // branch 0x010
    preload(12'h001, 16'h2000);  // memory opcode 010, no effect
    preload(12'h002, 16'hC000);  // indirect branch through 0
    preload(12'h010, 16'hF080);  // I/O, bit 7: enable
    preload(12'h011, 16'hF040);  // I/O, bit 6: disable
    preload(12'h012, 16'hF080);  // enable
    preload(12'h013, 16'hC030);  // indirect branch through 0x030
    preload(12'h030, 16'h0050);  // pointer
    preload(12'h050, 16'h7001);  // register instruction, no effect
    preload(12'h051, 16'h4050);  // branch 0x050
    @(negedge clk);
    pre_we = 1'b0;
    @(negedge clk);
    check(pc_o == '0 && step_o == '0, "R1", "reset pc/step",
          int'({pc_o, step_o}), 0);
    check(!ien_o && !r_o && ar_o == '0 && ir_o == '0, "R1", "reset flags/ar/ir",
          int'({ien_o, r_o, ar_o}), 0);
    #(CLK_PERIOD/4) rst = 1'b0;

    wait_bnd(12'h010);
    @(negedge clk);
    check(step_o == 4'd1 && ar_o == 12'h010, "R2", "step1 ar", int'(ar_o), 'h010);
    @(negedge clk);
    check(ir_o == 16'hF080, "R2", "step2 ir", int'(ir_o), 'hF080);
    check(pc_o == 12'h011, "R2", "step2 pc", int'(pc_o), 'h011);
    @(negedge clk);
    check(ar_o == 12'h080, "R3", "step3 ar address field", int'(ar_o), 'h080);

    wait_bnd(12'h013);
    @(negedge clk);
    @(negedge clk);
    check(ir_o == 16'hC030, "R2", "ir indirect branch", int'(ir_o), 'hC030);
    @(negedge clk);
    check(ar_o == 12'h030, "R5", "ar before pointer", int'(ar_o), 'h030);
    @(negedge clk);
    check(step_o == 4'd4 && ar_o == 12'h050, "R5", "ar after pointer",
          int'(ar_o), 'h050);

    wait_bnd(12'h051);
    wait_bnd(12'h051);
    #(CLK_PERIOD/4) in_rdy = 1'b1;

    do @(negedge clk); while (!(step_o == '0 && r_o));
    check(pc_o == 12'h050, "R7", "pc at pending boundary", int'(pc_o), 'h050);
    #(CLK_PERIOD/4) in_rdy = 1'b0;
    @(negedge clk);
    check(step_o == 4'd1 && ar_o == '0 && r_o, "R8", "entry step0 ar",
          int'(ar_o), 0);
    @(negedge clk);
    check(step_o == 4'd2 && pc_o == '0, "R8", "entry step1 pc", int'(pc_o), 0);
    @(negedge clk);
    check(step_o == '0 && pc_o == 12'h001 && !ien_o && !r_o, "R8", "entry end",
          int'({pc_o, ien_o, r_o}), 'h004);
    #(CLK_PERIOD/4) out_rdy = 1'b1;

    wait_bnd(12'h002);
    do @(negedge clk); while (step_o != '0);
    check(pc_o == 12'h050, "R9", "resume pc", int'(pc_o), 'h050);

    #(CLK_PERIOD/4);
    pre_we = 1'b1; pre_addr = 12'h051; pre_data = 16'h4010;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (step_o == '0)
        check(!r_o, "R10", "no pending without enable", int'(r_o), 0);
    end
    pre_we = 1'b0;
    check(exp_q.size() == 0, "R11", "boundaries left", exp_q.size(), 0);
    finish_run();
  end

endmodule